// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Array

This block models a 16-bit-wide static RAM whose control pins are all active low: a chip select, a write strobe, an output gate and one enable per byte lane. The memory is split into a low lane (bits 7:0) and a high lane (bits 15:8). Each lane is written and driven on its own. The pins are sampled on a system clock, so the block can be synthesized. A controller that would otherwise talk to an external asynchronous SRAM can use it in place of that part, with the same pin behaviour.

A write window is open for a lane while chip select, the write strobe and that lane's enable are all asserted at once. When any of the three is released, the window closes. The lane then stores the data present at the first clock edge that sees it closed, at the last address seen while the window was open.

Reads put the addressed word on `dq_out` one clock after the read is sampled. Each lane has its own output-enable flag, so the pad tristates can be built per lane. A standby flag reports when the device is deselected.

The controller is a four-state machine:
- `ST_STANDBY`: chip select is inactive.
- `ST_IDLE`: selected, but the outputs are gated off.
- `ST_READ`: a selected read with at least one lane enabled.
- `ST_WRITE`: a write window is open on at least one lane.

The next state is decoded afresh from the pins on every edge, so every state can be reached from every other. The named transitions are:
- deselect: any state to `ST_STANDBY` when chip select goes high.
- select: to `ST_IDLE`, `ST_READ` or `ST_WRITE` depending on the strobes.
- release: `ST_WRITE` to any other state, which commits the closing lanes.

Top module: `sram_byte_lane_array`

## Requirements
- R1: The array holds 2**ADDR_W words of 16 bits, with `addr` as the word index. The default ADDR_W is 10; ADDR_W=17 gives 131072 words.
- R2: A write stores only the lanes whose enable was low during the window: `lb_n` guards bits 7:0 and `ub_n` guards bits 15:8. A lane that was not enabled keeps its previous contents.
- R3: While `ce_n`=0, `we_n`=1 and `oe_n`=0 are sampled, then after that clock edge `dq_oe_lo` is 1 exactly when `lb_n` was 0, and `dq_oe_hi` is 1 exactly when `ub_n` was 0. The driven lanes of `dq_out` carry the word at the sampled address.
- R4: Both lane output enables are 0 after any edge that sampled `ce_n`=1, `oe_n`=1, `we_n`=0, or both lane enables high.
- R5: `standby` is 1 after an edge that sampled `ce_n`=1 and 0 after an edge that sampled `ce_n`=0. While `rst_n` is low, `standby` is 1 and nothing is driven.
- R6: A lane's window closes when `ce_n`, `we_n` or that lane's enable is released. The lane stores the `din` lane value sampled at the first edge that sees the window closed, at the last address sampled inside the window.
- R7: The lanes close independently. If `lb_n` rises while `ub_n`, `we_n` and `ce_n` stay low, the low lane commits at that edge and the high lane commits when its own window ends.
- R8: A write strobe with both lane enables high stores nothing.
- R9: A read sampled at least one edge after a window closed returns the committed data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| lb_n | input | 1 | Low-lane enable (bits 7:0), active low |
| ub_n | input | 1 | High-lane enable (bits 15:8), active low |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data from the pads |
| dq_out | output | 16 | Read data toward the pads |
| dq_oe_lo | output | 1 | Tristate enable for bits 7:0 |
| dq_oe_hi | output | 1 | Tristate enable for bits 15:8 |
| standby | output | 1 | High while deselected |

## Verification
The hardest case to reach from the pins is a window that closes on one lane while it stays open on the other. The data sampled at each lane's closing edge must then land only in that lane. The stimulus holds both lane enables and the write strobe low, raises `lb_n` alone with one data value, changes `din`, and then raises `ub_n`. A masked read afterwards shows that each byte came from a different edge. Writes ended by chip select, by the write strobe and by a lane enable are each compared against the bytes seen at the closing edge.

// File: rtl/sram_pkg.sv
package sram_pkg;
    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_IDLE    = 2'd1,
        ST_READ    = 2'd2,
        ST_WRITE   = 2'd3
    } sram_state_e;
endpackage

// File: rtl/sram_mode_decode.sv
// Decodes the sampled control pins into the next controller state and the
// per-lane write-window terms.
module sram_mode_decode
    import sram_pkg::*;
(
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [LANES-1:0]  be_n,
    output sram_state_e       mode_next,
    output logic [LANES-1:0]  lane_win
);
    logic any_lane;

    always_comb begin
        any_lane = |(~be_n);
        for (int i = 0; i < LANES; i++) begin
            lane_win[i] = ~ce_n & ~we_n & ~be_n[i];
        end
        unique case ({ce_n, we_n})
            2'b00:   mode_next = any_lane ? ST_WRITE : ST_IDLE;
            2'b01:   mode_next = (any_lane && !oe_n) ? ST_READ : ST_IDLE;
            default: mode_next = ST_STANDBY;
        endcase
    end
endmodule

// File: rtl/sram_ctrl_fsm.sv
// State register plus output decode: lane drive enables and standby flag.
module sram_ctrl_fsm
    import sram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  sram_state_e       mode_next,
    input  logic [LANES-1:0]  be_n,
    output sram_state_e       state,
    output logic [LANES-1:0]  drv_lane,
    output logic              standby
);
    logic [LANES-1:0] lane_sel_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_STANDBY;
            lane_sel_q <= '0;
        end else begin
            state      <= mode_next;
            lane_sel_q <= ~be_n;
        end
    end

    always_comb begin
        drv_lane = '0;
        standby  = 1'b0;
        unique case (state)
            ST_STANDBY: standby  = 1'b1;
            ST_IDLE:    drv_lane = '0;
            ST_READ:    drv_lane = lane_sel_q;
            ST_WRITE:   drv_lane = '0;
            default:    standby  = 1'b1;
        endcase
    end
endmodule

// File: rtl/sram_lane_bank.sv
// One byte lane: storage, close-edge commit, registered read port.
module sram_lane_bank #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_now,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] din,
    input  logic              rd_en,
    output logic [LANE_W-1:0] rd_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];
    logic              win_q;
    logic [ADDR_W-1:0] addr_q;
    logic              commit;

    assign commit = win_q & ~win_now;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            win_q <= win_now;
            if (win_now) begin
                addr_q <= addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n && commit) begin
            mem[addr_q] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= mem[addr];
        end
    end
endmodule

// File: rtl/sram_byte_lane_array.sv
module sram_byte_lane_array
    import sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              lb_n,
    input  logic              ub_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_oe_lo,
    output logic              dq_oe_hi,
    output logic              standby
);
    logic [LANES-1:0] be_n;
    logic [LANES-1:0] lane_win;
    logic [LANES-1:0] drv_lane;
    sram_state_e      mode_next;
    sram_state_e      state;
    logic             rd_en;

    assign be_n  = {ub_n, lb_n};
    assign rd_en = (mode_next == ST_READ);

    sram_mode_decode u_dec (
        .ce_n      (ce_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .be_n      (be_n),
        .mode_next (mode_next),
        .lane_win  (lane_win)
    );

    sram_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_next (mode_next),
        .be_n      (be_n),
        .state     (state),
        .drv_lane  (drv_lane),
        .standby   (standby)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_lane_bank #(
            .ADDR_W (ADDR_W),
            .LANE_W (LANE_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .win_now (lane_win[g]),
            .addr    (addr),
            .din     (din[g*LANE_W +: LANE_W]),
            .rd_en   (rd_en),
            .rd_q    (dq_out[g*LANE_W +: LANE_W])
        );
    end

    assign dq_oe_lo = drv_lane[0];
    assign dq_oe_hi = drv_lane[1];
endmodule

// File: rtl/sram_checker.sv
module sram_checker (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic we_n,
    input logic oe_n,
    input logic lb_n,
    input logic ub_n,
    input logic dq_oe_lo,
    input logic dq_oe_hi,
    input logic standby
);
    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |=> (!dq_oe_lo && !dq_oe_hi)); // R4
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (standby && !dq_oe_lo && !dq_oe_hi)); // R5
    AST_SELECT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |=> !standby); // R5
    AST_READ_LO_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && !oe_n && !lb_n) |=> dq_oe_lo); // R3
    AST_READ_HI_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && !oe_n && ub_n) |=> !dq_oe_hi); // R3
    AST_GATE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && we_n) |=> (!dq_oe_lo && !dq_oe_hi)); // R4
endmodule

bind sram_byte_lane_array sram_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .lb_n     (lb_n),
    .ub_n     (ub_n),
    .dq_oe_lo (dq_oe_lo),
    .dq_oe_hi (dq_oe_hi),
    .standby  (standby)
);

// File: tb/tb_sram_byte_lane_array.sv
module tb_sram_byte_lane_array;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce_n, we_n, oe_n, lb_n, ub_n;
    logic [AW-1:0] addr;
    logic [15:0]   din;
    logic [15:0]   dq_out;
    logic          dq_oe_lo, dq_oe_hi, standby;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    sram_byte_lane_array #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .din(din),
        .dq_out(dq_out), .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi),
        .standby(standby)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive pins right after a falling edge, let one rising edge sample them,
    // return at the next falling edge where outputs are stable.
    task automatic apply(logic c, logic w, logic o, logic u, logic l,
                         logic [AW-1:0] a, logic [15:0] d);
        ce_n = c; we_n = w; oe_n = o; ub_n = u; lb_n = l; addr = a; din = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0, 16'h0000);
    endtask

    task automatic read_chk(string req, logic [AW-1:0] a, logic u, logic l,
                            logic [15:0] exp);
        apply(1'b0, 1'b1, 1'b0, u, l, a, 16'h0000);
        check({req, " lo drive"}, {31'd0, dq_oe_lo}, {31'd0, ~l});
        check({req, " hi drive"}, {31'd0, dq_oe_hi}, {31'd0, ~u});
        if (!l) check({req, " lo data"}, {24'd0, dq_out[7:0]},  {24'd0, exp[7:0]});
        if (!u) check({req, " hi data"}, {24'd0, dq_out[15:8]}, {24'd0, exp[15:8]});
        idle();
    endtask

    // Full-word write closed by the write strobe.
    task automatic write_word(logic [AW-1:0] a, logic [15:0] d);
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, 16'hDEAD);
        apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, a, d);
        idle();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, 16'h0000);
        check("R5 reset standby", {31'd0, standby}, 32'd1);
        check("R5 reset no drive", {30'd0, dq_oe_hi, dq_oe_lo}, 32'd0);
        rst_n = 1'b1;
        idle();
    endtask

    task automatic t_full_word();
        write_word(10'h005, 16'hA55A);
        read_chk("R3 full read", 10'h005, 1'b0, 1'b0, 16'hA55A);
        read_chk("R3 low only", 10'h005, 1'b1, 1'b0, 16'hA55A);
        read_chk("R3 high only", 10'h005, 1'b0, 1'b1, 16'hA55A);
        read_chk("R9 read after close", 10'h005, 1'b0, 1'b0, 16'hA55A);
    endtask

    task automatic t_lane_mask();
        write_word(10'h010, 16'h1234);
        apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'h010, 16'hFFFF);
        apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 10'h010, 16'hBEEF);
        idle();
        read_chk("R2 low lane write", 10'h010, 1'b0, 1'b0, 16'h12EF);
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 10'h010, 16'h0000);
        apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 10'h010, 16'h77CC);
        idle();
        read_chk("R2 high lane write", 10'h010, 1'b0, 1'b0, 16'h77EF);
    endtask

    task automatic t_close_by_ce();
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'h020, 16'h1111);
        apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10'h020, 16'h4321);
        check("R5 deselect standby", {31'd0, standby}, 32'd1);
        idle();
        read_chk("R6 close by chip select", 10'h020, 1'b0, 1'b0, 16'h4321);
    endtask

    task automatic t_stagger();
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'h030, 16'h0000);
        check("R4 write no drive", {30'd0, dq_oe_hi, dq_oe_lo}, 32'd0);
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 10'h030, 16'h99AB);
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 10'h030, 16'h5566);
        apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'h030, 16'hC3FF);
        idle();
        read_chk("R7 staggered lanes", 10'h030, 1'b0, 1'b0, 16'hC3AB);
    endtask

    task automatic t_no_lane_write();
        write_word(10'h040, 16'h0F0F);
        apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'h040, 16'hFFFF);
        apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 10'h040, 16'hFFFF);
        idle();
        read_chk("R8 no lane write", 10'h040, 1'b0, 1'b0, 16'h0F0F);
    endtask

    task automatic t_gating();
        apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 10'h005, 16'h0000);
        check("R4 output gate off", {30'd0, dq_oe_hi, dq_oe_lo}, 32'd0);
        check("R5 selected not standby", {31'd0, standby}, 32'd0);
        apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 10'h005, 16'h0000);
        check("R4 both lanes off", {30'd0, dq_oe_hi, dq_oe_lo}, 32'd0);
        apply(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'h005, 16'h0000);
        check("R4 deselected read", {30'd0, dq_oe_hi, dq_oe_lo}, 32'd0);
        check("R5 standby flag", {31'd0, standby}, 32'd1);
        idle();
    endtask

    task automatic t_bounds();
        write_word('0, 16'h0102);
        write_word('1, 16'hFEDC);
        read_chk("R1 lowest address", '0, 1'b0, 1'b0, 16'h0102);
        read_chk("R1 highest address", '1, 1'b0, 1'b0, 16'hFEDC);
    endtask

    initial begin
        rst_n = 1'b0;
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
        addr = '0; din = '0;
        @(negedge clk);
        t_reset();
        t_full_word();
        t_lane_mask();
        t_close_by_ce();
        t_stagger();
        t_no_lane_write();
        t_gating();
        t_bounds();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule